// File: doc/BRIEF.md
# Shift Unit With Carry Flag

This is a purely combinational shift stage for a processor datapath. It moves the bits of an 8-bit or 16-bit operand left or right by a count. The count is either an immediate one or the value held in a count register. On the way it produces a flag set: carry, zero, sign, parity and overflow. Left shifts share one path whether they are named logical or arithmetic. Right shifts pick between zero fill and copies of the sign bit. Carry always holds the final bit pushed out of the operand, however many positions were shifted.

The caller applies the operand, the operation, the count source and the width on one side. It takes the result, the flags and a flag-write strobe on the other. The strobe says whether the architectural flags should be updated at all: a zero count leaves them untouched. The block holds no state and needs no clock. There is no handshake because every output is valid once the inputs settle.

Top module: `shift_flag_unit`

## Requirements
- R1: The two left operations (op 2'b00 logical, 2'b01 arithmetic) give identical result and flag outputs for every operand and count.
- R2: A left shift by n moves each bit n places toward the MSB and fills the n lowest positions with zeros.
- R3: A logical right shift (op 2'b10) by n moves each bit toward the LSB and fills the n top positions with zeros.
- R4: An arithmetic right shift (op 2'b11) fills every vacated top position with the original MSB, so the sign is kept.
- R5: Carry is the last bit that leaves the operand. On a left shift that bit leaves from the MSB end, and on a right shift it leaves from the LSB end. For counts above one it is the final such bit, not the first.
- R6: With cnt_from_reg_i low the count is one whatever cnt_reg_i holds. With it high, the count is the 8-bit value on cnt_reg_i.
- R7: Zero is set when the result is all zeros, and sign equals the result MSB. Parity is set when bits [7:0] of the result hold an even number of ones.
- R8: A count of zero returns the operand unchanged and drives flag_we_o low. Any non-zero count drives flag_we_o high.
- R9: Overflow is meaningful only for a count of one. For a left shift it is the new MSB XOR carry, for a logical right shift it is the original MSB, and for an arithmetic right shift it is zero. It is zero for every other count.
- R10: wide_i high selects 16-bit operation with the MSB at bit 15. wide_i low selects 8-bit operation with the MSB at bit 7; operand bits [15:8] are ignored and result bits [15:8] are zero.
- R11: For a count of at least the operand width, logical shifts give zero and an arithmetic right shift gives all copies of the sign. Carry is what repeated single shifts would leave: the last original bit at exactly the width, and the fill bit beyond it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 16 | Value to shift (low byte only in 8-bit mode) |
| op_i | input | 2 | 00 left logical, 01 left arithmetic, 10 right logical, 11 right arithmetic |
| cnt_from_reg_i | input | 1 | 0: count is one; 1: count from cnt_reg_i |
| cnt_reg_i | input | 8 | Count register value |
| wide_i | input | 1 | 1: 16-bit operation; 0: 8-bit operation |
| result_o | output | 16 | Shifted value |
| carry_o | output | 1 | Last bit shifted out |
| zero_o | output | 1 | Result is zero |
| sign_o | output | 1 | Result MSB |
| parity_o | output | 1 | Even number of ones in result bits [7:0] |
| overflow_o | output | 1 | Sign-change indicator for a count of one |
| flag_we_o | output | 1 | Flags should be written (count non-zero) |

## Verification
The bench targets counts at and just beyond the operand width. A design that wraps the count would return a partly shifted value there instead of zeros or sign copies, and would take carry from the wrong bit. It also covers 8-bit mode, where a unit that takes its MSB from bit 15 would report wrong sign, overflow and arithmetic fill. It sets a register count while the immediate source is selected, which catches a broken count mux. It uses counts above one, where a design that latches the first bit shifted out gives a wrong carry. It also checks that overflow drops to zero once the count exceeds one.

// File: rtl/shu_pkg.sv
package shu_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_ASL = 2'b01,
    SH_LSR = 2'b10,
    SH_ASR = 2'b11
  } shift_op_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic pf;
    logic of;
  } shift_flags_t;

endpackage

// File: rtl/shu_count_sel.sv
module shu_count_sel #(
  parameter int CNT_W = 8,
  parameter int LIMIT = 16,
  parameter int SAT_W = $clog2(LIMIT + 2)
) (
  input  logic             from_reg_i,
  input  logic [CNT_W-1:0] cnt_reg_i,
  output logic [SAT_W-1:0] sat_cnt_o,
  output logic             is_zero_o,
  output logic             is_one_o
);

  logic [CNT_W-1:0] raw_cnt;

  assign raw_cnt   = from_reg_i ? cnt_reg_i : CNT_W'(1);
  assign is_zero_o = (raw_cnt == '0);
  assign is_one_o  = (raw_cnt == CNT_W'(1));

  // Anything past the width behaves like width+1: every original bit and
  // at least one fill bit have left the operand.
  always_comb begin
    if (int'(raw_cnt) > LIMIT) sat_cnt_o = SAT_W'(LIMIT + 1);
    else                       sat_cnt_o = SAT_W'(raw_cnt);
  end

endmodule

// File: rtl/shu_shift_core.sv
module shu_shift_core #(
  parameter int W     = 16,
  parameter int SAT_W = $clog2(W + 2)
) (
  input  logic [W-1:0]     a_i,
  input  logic             right_i,
  input  logic             arith_i,
  input  logic [SAT_W-1:0] sh_i,
  output logic [W-1:0]     res_o,
  output logic             cout_o
);

  // One extra slot beside the operand collects the bit pushed out.
  localparam int EW = W + 1;

  logic          fill;
  logic [EW-1:0] lv [0:SAT_W];
  logic [EW-1:0] rv [0:SAT_W];

  assign fill  = arith_i & a_i[W-1];
  assign lv[0] = {1'b0, a_i};
  assign rv[0] = {a_i, 1'b0};

  for (genvar k = 0; k < SAT_W; k++) begin : g_stage
    localparam int S = 1 << k;
    if (S < EW) begin : g_part
      assign lv[k+1] = sh_i[k] ? {lv[k][EW-1-S:0], {S{1'b0}}} : lv[k];
      assign rv[k+1] = sh_i[k] ? {{S{fill}}, rv[k][EW-1:S]}   : rv[k];
    end else begin : g_full
      assign lv[k+1] = sh_i[k] ? '0         : lv[k];
      assign rv[k+1] = sh_i[k] ? {EW{fill}} : rv[k];
    end
  end

  assign res_o  = right_i ? rv[SAT_W][EW-1:1] : lv[SAT_W][W-1:0];
  assign cout_o = right_i ? rv[SAT_W][0]      : lv[SAT_W][W];

endmodule

// File: rtl/shu_flag_gen.sv
module shu_flag_gen
  import shu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]  res_i,
  input  logic          cout_i,
  input  logic          orig_msb_i,
  input  shift_op_e     op_i,
  input  logic          is_one_i,
  output shift_flags_t  flags_o
);

  always_comb begin
    flags_o.cf = cout_i;
    flags_o.zf = (res_i == '0);
    flags_o.sf = res_i[W-1];
    flags_o.pf = ~^res_i[7:0];
    flags_o.of = 1'b0;
    if (is_one_i) begin
      unique case (op_i)
        SH_LSL, SH_ASL: flags_o.of = res_i[W-1] ^ cout_i;
        SH_LSR:         flags_o.of = orig_msb_i;
        SH_ASR:         flags_o.of = 1'b0;
        default:        flags_o.of = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
  import shu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int CNT_W    = 8
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [1:0]        op_i,
  input  logic              cnt_from_reg_i,
  input  logic [CNT_W-1:0]  cnt_reg_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic              sign_o,
  output logic              parity_o,
  output logic              overflow_o,
  output logic              flag_we_o
);

  localparam int NLANE = 2;

  shift_op_e    op;
  logic         right, arith;
  logic [DATA_W-1:0] lane_res   [NLANE];
  shift_flags_t      lane_flags [NLANE];
  logic              lane_zero  [NLANE];
  shift_flags_t      sel_flags;

  assign op    = shift_op_e'(op_i);
  assign right = op_i[1];
  assign arith = op_i[0];

  // Lane 0 is the narrow datapath, lane 1 the full-width one.
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = (g == 0) ? NARROW_W : DATA_W;
    localparam int SW = $clog2(LW + 2);

    logic [SW-1:0] sat_cnt;
    logic          is_one;
    logic [LW-1:0] core_res;
    logic          core_cout;

    shu_count_sel #(.CNT_W(CNT_W), .LIMIT(LW), .SAT_W(SW)) u_cnt (
      .from_reg_i (cnt_from_reg_i),
      .cnt_reg_i  (cnt_reg_i),
      .sat_cnt_o  (sat_cnt),
      .is_zero_o  (lane_zero[g]),
      .is_one_o   (is_one)
    );

    shu_shift_core #(.W(LW), .SAT_W(SW)) u_core (
      .a_i     (operand_i[LW-1:0]),
      .right_i (right),
      .arith_i (arith),
      .sh_i    (sat_cnt),
      .res_o   (core_res),
      .cout_o  (core_cout)
    );

    shu_flag_gen #(.W(LW)) u_flags (
      .res_i      (core_res),
      .cout_i     (core_cout),
      .orig_msb_i (operand_i[LW-1]),
      .op_i       (op),
      .is_one_i   (is_one),
      .flags_o    (lane_flags[g])
    );

    assign lane_res[g] = DATA_W'(core_res);
  end

  assign result_o   = wide_i ? lane_res[1]   : lane_res[0];
  assign sel_flags  = wide_i ? lane_flags[1] : lane_flags[0];
  assign flag_we_o  = wide_i ? !lane_zero[1] : !lane_zero[0];
  assign carry_o    = sel_flags.cf;
  assign zero_o     = sel_flags.zf;
  assign sign_o     = sel_flags.sf;
  assign parity_o   = sel_flags.pf;
  assign overflow_o = sel_flags.of;

endmodule

// File: rtl/shift_flag_unit_chk.sv
module shift_flag_unit_chk #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int CNT_W    = 8
) (
  input logic [DATA_W-1:0] operand_i,
  input logic [1:0]        op_i,
  input logic              cnt_from_reg_i,
  input logic [CNT_W-1:0]  cnt_reg_i,
  input logic              wide_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              zero_o,
  input logic              sign_o,
  input logic              parity_o,
  input logic              overflow_o,
  input logic              flag_we_o
);

  logic [CNT_W-1:0]  eff_cnt;
  logic [DATA_W-1:0] lane_mask;
  int unsigned       top_bit;
  int unsigned       lane_w;

  assign eff_cnt   = cnt_from_reg_i ? cnt_reg_i : CNT_W'(1);
  assign lane_mask = wide_i ? '1 : DATA_W'({NARROW_W{1'b1}});
  assign top_bit   = wide_i ? DATA_W - 1 : NARROW_W - 1;
  assign lane_w    = wide_i ? DATA_W : NARROW_W;

  always_comb begin
    if (eff_cnt == '0) begin
      a_r8_idle_passthru: assert (!flag_we_o && result_o == (operand_i & lane_mask))
        else $error("R8: zero count altered result or raised flag write");
    end
    if (flag_we_o) begin
      a_r7_zero_tracks: assert (zero_o == (result_o == '0))
        else $error("R7: zero flag disagrees with result");
      a_r7_sign_tracks: assert (sign_o == result_o[top_bit])
        else $error("R7: sign flag disagrees with result MSB");
      a_r7_parity_tracks: assert (parity_o == ($countones(result_o[7:0]) % 2 == 0))
        else $error("R7: parity flag disagrees with low byte");
    end
    if (int'(eff_cnt) > 1) begin
      a_r9_no_overflow: assert (!overflow_o)
        else $error("R9: overflow set for multi-bit count");
    end
    if (!wide_i) begin
      a_r10_upper_clear: assert (result_o[DATA_W-1:NARROW_W] == '0)
        else $error("R10: upper byte nonzero in narrow mode");
    end
    if (op_i == 2'b11 && int'(eff_cnt) >= int'(lane_w)) begin
      a_r11_asr_saturate: assert (result_o == (operand_i[top_bit] ? lane_mask : '0)
                                  && carry_o == operand_i[top_bit])
        else $error("R11: arithmetic right shift past width not all sign");
    end
  end

endmodule

bind shift_flag_unit shift_flag_unit_chk #(
  .DATA_W(DATA_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W)
) u_chk (
  .operand_i(operand_i), .op_i(op_i), .cnt_from_reg_i(cnt_from_reg_i),
  .cnt_reg_i(cnt_reg_i), .wide_i(wide_i), .result_o(result_o),
  .carry_o(carry_o), .zero_o(zero_o), .sign_o(sign_o), .parity_o(parity_o),
  .overflow_o(overflow_o), .flag_we_o(flag_we_o)
);

// File: tb/shift_flag_unit_tb_top.sv
module shift_flag_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] operand;
  logic [1:0]  op;
  logic        from_reg;
  logic [7:0]  cnt_reg;
  logic        wide;
  logic [15:0] result;
  logic        carry, zero, sign, parity, ovf, we;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  shift_flag_unit dut_i (
    .operand_i(operand), .op_i(op), .cnt_from_reg_i(from_reg),
    .cnt_reg_i(cnt_reg), .wide_i(wide), .result_o(result),
    .carry_o(carry), .zero_o(zero), .sign_o(sign), .parity_o(parity),
    .overflow_o(ovf), .flag_we_o(we)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: repeated single-bit shifts on integers.
  task automatic ref_model(input logic [1:0] m_op, input logic [15:0] a,
                           input logic fr, input logic [7:0] cr, input logic w,
                           output int r, output int cf, output int zf,
                           output int sf, output int pf, output int of, output int fw);
    int wd, n, mask, v, c, fill, ones;
    wd = w ? 16 : 8;
    n = fr ? int'(cr) : 1;
    mask = (1 << wd) - 1;
    v = int'(a) & mask;
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (!m_op[1]) begin
        c = (v >> (wd - 1)) & 1;
        v = (v << 1) & mask;
      end else begin
        c = v & 1;
        fill = m_op[0] ? ((v >> (wd - 1)) & 1) : 0;
        v = (v >> 1) | (fill << (wd - 1));
      end
    end
    ones = 0;
    for (int i = 0; i < 8; i++) ones += (v >> i) & 1;
    r  = v;
    cf = c;
    zf = (v == 0) ? 1 : 0;
    sf = (v >> (wd - 1)) & 1;
    pf = (ones % 2 == 0) ? 1 : 0;
    fw = (n != 0) ? 1 : 0;
    of = 0;
    if (n == 1) begin
      if (!m_op[1])      of = sf ^ c;
      else if (!m_op[0]) of = (int'(a) >> (wd - 1)) & 1;
    end
  endtask

  task automatic apply(string req, logic [1:0] t_op, logic [15:0] a,
                       logic fr, logic [7:0] cr, logic w);
    int r, cf, zf, sf, pf, of, fw;
    @(posedge clk);
    op = t_op; operand = a; from_reg = fr; cnt_reg = cr; wide = w;
    @(negedge clk);
    ref_model(t_op, a, fr, cr, w, r, cf, zf, sf, pf, of, fw);
    chk(req, "R2/R3/R4 result", int'(result), r);
    chk(req, "R5 carry", int'(carry), cf);
    chk(req, "R7 zero", int'(zero), zf);
    chk(req, "R7 sign", int'(sign), sf);
    chk(req, "R7 parity", int'(parity), pf);
    chk(req, "R9 overflow", int'(ovf), of);
    chk(req, "R8 flag_we", int'(we), fw);
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
  endtask

  initial begin
    logic [15:0] r_l;
    logic [4:0]  f_l;
    operand = '0; op = 2'b00; from_reg = 1'b1; cnt_reg = 8'd0; wide = 1'b1;
    repeat (3) @(negedge clk);
    // Reset state: zero count from register, zero operand.
    chk("R8", "reset result", int'(result), 0);
    chk("R8", "reset flag_we", int'(we), 0);
    rst = 1'b0;

    // Hand-computed single shifts, 8-bit, operand 0x81.
    apply("R2", 2'b00, 16'h0081, 1'b0, 8'd0, 1'b0);
    chk("R2", "lsl1 result", int'(result), 'h02);
    chk("R9", "lsl1 ovf", int'(ovf), 1);
    apply("R3", 2'b10, 16'h0081, 1'b0, 8'd0, 1'b0);
    chk("R3", "lsr1 result", int'(result), 'h40);
    chk("R9", "lsr1 ovf", int'(ovf), 1);
    apply("R4", 2'b11, 16'h0081, 1'b0, 8'd0, 1'b0);
    chk("R4", "asr1 result", int'(result), 'hC0);
    chk("R5", "asr1 carry", int'(carry), 1);
    chk("R9", "asr1 ovf", int'(ovf), 0);

    // R6: register value ignored when immediate one selected.
    apply("R6", 2'b10, 16'hF000, 1'b0, 8'd5, 1'b1);
    chk("R6", "imm one result", int'(result), 'h7800);
    apply("R6", 2'b10, 16'hF000, 1'b1, 8'd5, 1'b1);
    chk("R6", "reg five result", int'(result), 'h0780);

    // R5: multi-bit carry is the last bit out (bit 12 of 0x1F00 after 4).
    apply("R5", 2'b00, 16'h1F00, 1'b1, 8'd4, 1'b1);
    chk("R5", "lsl4 carry", int'(carry), 1);
    apply("R5", 2'b00, 16'h8F00, 1'b1, 8'd4, 1'b1);
    chk("R5", "lsl4 carry first-bit trap", int'(carry), 0);

    // R8: zero count passes operand.
    apply("R8", 2'b11, 16'hA5C3, 1'b1, 8'd0, 1'b1);
    chk("R8", "zero count result", int'(result), 'hA5C3);
    chk("R8", "zero count we", int'(we), 0);

    // R10: narrow mode ignores upper operand byte.
    apply("R10", 2'b11, 16'hFF40, 1'b1, 8'd2, 1'b0);
    chk("R10", "narrow asr result", int'(result), 'h10);
    apply("R10", 2'b11, 16'h0080, 1'b1, 8'd2, 1'b0);
    chk("R10", "narrow asr sign", int'(result), 'hE0);

    // R11: counts at and past width.
    apply("R11", 2'b10, 16'h8001, 1'b1, 8'd16, 1'b1);
    chk("R11", "lsr16 result", int'(result), 0);
    chk("R11", "lsr16 carry", int'(carry), 1);
    apply("R11", 2'b10, 16'h8001, 1'b1, 8'd17, 1'b1);
    chk("R11", "lsr17 carry", int'(carry), 0);
    apply("R11", 2'b11, 16'h8000, 1'b1, 8'd200, 1'b1);
    chk("R11", "asr200 result", int'(result), 'hFFFF);
    chk("R11", "asr200 carry", int'(carry), 1);
    apply("R11", 2'b00, 16'h0001, 1'b1, 8'd16, 1'b1);
    chk("R11", "lsl16 carry", int'(carry), 1);
    apply("R11", 2'b00, 16'h0001, 1'b1, 8'd8, 1'b0);
    chk("R11", "narrow lsl8 carry", int'(carry), 1);

    // R1: both left encodings agree.
    for (int i = 0; i < 40; i++) begin
      logic [15:0] a;
      logic [7:0]  c;
      logic        w;
      a = 16'($urandom);
      c = 8'($urandom % 20);
      w = 1'($urandom);
      apply("R1", 2'b00, a, 1'b1, c, w);
      r_l = result;
      f_l = {carry, zero, sign, parity, ovf};
      apply("R1", 2'b01, a, 1'b1, c, w);
      chk("R1", "asl vs lsl result", int'(result), int'(r_l));
      chk("R1", "asl vs lsl flags", int'({carry, zero, sign, parity, ovf}), int'(f_l));
    end

    // Random sweep across every mode.
    for (int i = 0; i < 1500; i++) begin
      logic [7:0] c;
      c = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 19);
      apply("R11", 2'($urandom), 16'($urandom), 1'($urandom % 4 != 0), c, 1'($urandom));
    end

    report();
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
      $finish;
    end
  end

endmodule